// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital control section of a dual-slope integrating converter. A prescaler divides the input clock by a fixed ratio and produces one count step per ratio period. A chain of BCD decade counters advances on those steps. A phase controller uses the counter to move the converter through three phases in a fixed order: auto-zero, then signal integrate, then reference de-integrate. One-hot phase outputs drive the analog switches. The analog integrator, the comparator circuit, the oscillator and the display drive levels sit outside this block.

Signal integrate always lasts a fixed number of counts. During de-integrate the counter restarts from zero and runs until the comparator input settles at a level different from its level when the phase began. At that point the count is the measurement, and it is captured into a BCD result latch. If no crossing happens, the latch instead records an overrange. Auto-zero takes whatever part of the de-integrate window went unused, so a full conversion always takes the same number of counts. A hold input freezes the latch while conversions keep running. Each latched digit also drives a seven-segment pattern.

Top module: `dslope_sequencer`

## Requirements
- R1: Reset is synchronous and active high. During reset, only ph_az is asserted, rdg_bcd is zero and rdg_ovr is low. The first auto-zero after reset lasts 3000 counts, so ph_int first rises 12000 clocks after the first clock edge with reset low.
- R2: Exactly one of ph_az, ph_int and ph_deint is high in every cycle. The phases always follow the order auto-zero, integrate, de-integrate, auto-zero.
- R3: The counter advances once every PRESCALE (4) input clocks, and a phase can change only on such a step. Signal integrate lasts INT_COUNTS (1000) counts, which is 4000 clocks.
- R4: The comparator input passes through two flip-flops. De-integrate starts counting from zero. It ends on the first count step at which the synchronized comparator level differs from its level at the start of de-integrate. When that happens at count N, de-integrate has lasted N+1 counts.
- R5: At the crossing, the count N is loaded into rdg_bcd as four BCD digits: bits 3:0 units, 7:4 tens, 11:8 hundreds, 15:12 thousands. rdg_ovr is cleared, and the latch changes at no other time.
- R6: If no crossing occurs by count DEINT_MAX-1 (1999), de-integrate ends after 2000 counts. rdg_ovr is then set and rdg_bcd reads 1999.
- R7: Every full conversion lasts CYCLE_COUNTS (4000) counts, which is 16000 clocks, whatever the crossing point. Auto-zero takes the remaining counts.
- R8: While hold_in is high, rdg_bcd and rdg_ovr do not change, but the phases keep running. The first capture after hold_in returns low updates the latch again.
- R9: seg_out[7*i+6 : 7*i] shows digit i of rdg_bcd. Bit 0 is segment a and bit 6 is segment g, active high. The patterns for 0 through 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator level |
| hold_in | input | 1 | High freezes the result latch |
| ph_az | output | 1 | Auto-zero phase switch control |
| ph_int | output | 1 | Signal-integrate phase switch control |
| ph_deint | output | 1 | Reference de-integrate phase switch control |
| rdg_bcd | output | 16 | Latched reading, four BCD digits |
| rdg_ovr | output | 1 | Latched overrange flag |
| seg_out | output | 28 | Seven-segment patterns, 7 bits per digit, units lowest |

## Verification
The assertions check, on every cycle, the properties that hold everywhere:
- exactly one phase is active;
- the phase order is kept;
- phases change only on a count step;
- de-integrate never runs beyond its 2000-count window;
- held or idle cycles leave the latch alone;
- an overrange always reads 1999.

Only the bench scenarios can show that the latched value equals the crossing count. They check this at zero, at mid-scale and at the last count. The bench also shows that conversions stay 16000 clocks long for every crossing point, that a conversion run under hold is discarded while the next one is kept, and that the first auto-zero after reset has the right length.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    localparam int unsigned DIG_N = 4;
    localparam int unsigned SEG_W = 7;
    localparam int unsigned BCD_W = 4 * DIG_N;

    typedef logic [3:0]            bcd_t;
    typedef bcd_t [DIG_N-1:0]      bcd_vec_t;

    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2
    } phase_e;

    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_cmd_t;

    typedef struct packed {
        logic load;
        logic ovr;
    } cap_cmd_t;

    function automatic bcd_vec_t to_bcd(input int unsigned v);
        bcd_vec_t    r;
        int unsigned rem;
        rem = v;
        for (int i = 0; i < DIG_N; i++) begin
            r[i] = bcd_t'(rem % 10);
            rem  = rem / 10;
        end
        return r;
    endfunction

    function automatic logic [SEG_W-1:0] seg7(input bcd_t d);
        logic [SEG_W-1:0] s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dslope_prescaler.sv
module dslope_prescaler #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    assign tick = (cnt == W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dslope_sync2.sv
module dslope_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/dslope_bcd_counter.sv
module dslope_bcd_counter
    import dslope_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_cmd_t cmd,
    output bcd_vec_t value
);
    logic [DIG_N:0] carry;

    assign carry[0] = cmd.inc;

    for (genvar i = 0; i < DIG_N; i++) begin : g_dig
        bcd_t dig;

        assign carry[i+1] = carry[i] & (dig == 4'd9);
        assign value[i]   = dig;

        always_ff @(posedge clk) begin
            if (rst || cmd.clr) dig <= '0;
            else if (carry[i])  dig <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
        end
    end
endmodule

// File: rtl/dslope_phase_ctrl.sv
module dslope_phase_ctrl
    import dslope_pkg::*;
#(
    parameter int unsigned INT_COUNTS   = 1000,
    parameter int unsigned DEINT_MAX    = 2000,
    parameter int unsigned CYCLE_COUNTS = 4000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     cmp_lvl,
    input  bcd_vec_t cnt,
    output phase_e   phase,
    output cnt_cmd_t cmd,
    output cap_cmd_t cap
);
    localparam bcd_vec_t INT_LAST   = to_bcd(INT_COUNTS - 1);
    localparam bcd_vec_t DEINT_LAST = to_bcd(DEINT_MAX - 1);
    localparam bcd_vec_t AZ_LAST    = to_bcd(CYCLE_COUNTS - INT_COUNTS - 1);

    phase_e phase_q, phase_d;
    logic   arm_q;
    logic   arm_ld;

    always_comb begin
        phase_d = phase_q;
        cmd     = '0;
        cap     = '0;
        arm_ld  = 1'b0;
        if (tick) begin
            case (phase_q)
                PH_AZ: begin
                    if (cnt == AZ_LAST) begin
                        phase_d = PH_INT;
                        cmd.clr = 1'b1;
                    end else begin
                        cmd.inc = 1'b1;
                    end
                end
                PH_INT: begin
                    if (cnt == INT_LAST) begin
                        phase_d = PH_DEINT;
                        cmd.clr = 1'b1;
                        arm_ld  = 1'b1;
                    end else begin
                        cmd.inc = 1'b1;
                    end
                end
                PH_DEINT: begin
                    cmd.inc = 1'b1;
                    if (cmp_lvl != arm_q) begin
                        cap.load = 1'b1;
                        phase_d  = PH_AZ;
                    end else if (cnt == DEINT_LAST) begin
                        cap.load = 1'b1;
                        cap.ovr  = 1'b1;
                        phase_d  = PH_AZ;
                    end
                end
                default: begin
                    phase_d = PH_AZ;
                    cmd.clr = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_AZ;
            arm_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (arm_ld) arm_q <= cmp_lvl;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/dslope_result.sv
module dslope_result
    import dslope_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  cap_cmd_t               cap,
    input  logic                   hold,
    input  bcd_vec_t               cnt,
    output bcd_vec_t               rdg,
    output logic                   ovr,
    output logic [DIG_N*SEG_W-1:0] seg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdg <= '0;
            ovr <= 1'b0;
        end else if (cap.load && !hold) begin
            rdg <= cnt;
            ovr <= cap.ovr;
        end
    end

    for (genvar i = 0; i < DIG_N; i++) begin : g_seg
        assign seg[i*SEG_W +: SEG_W] = seg7(rdg[i]);
    end
endmodule

// File: rtl/dslope_sequencer.sv
module dslope_sequencer
    import dslope_pkg::*;
#(
    parameter int unsigned PRESCALE     = 4,
    parameter int unsigned INT_COUNTS   = 1000,
    parameter int unsigned DEINT_MAX    = 2000,
    parameter int unsigned CYCLE_COUNTS = 4000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmp_in,
    input  logic                   hold_in,
    output logic                   ph_az,
    output logic                   ph_int,
    output logic                   ph_deint,
    output logic [BCD_W-1:0]       rdg_bcd,
    output logic                   rdg_ovr,
    output logic [DIG_N*SEG_W-1:0] seg_out
);
    logic     pre_tick;
    logic     cmp_lvl;
    phase_e   phase;
    cnt_cmd_t cnt_cmd;
    cap_cmd_t cap_cmd;
    bcd_vec_t cnt_val;
    bcd_vec_t rdg;

    dslope_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (pre_tick)
    );

    dslope_sync2 u_cmp_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_in),
        .q   (cmp_lvl)
    );

    dslope_bcd_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cnt_cmd),
        .value (cnt_val)
    );

    dslope_phase_ctrl #(
        .INT_COUNTS   (INT_COUNTS),
        .DEINT_MAX    (DEINT_MAX),
        .CYCLE_COUNTS (CYCLE_COUNTS)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick    (pre_tick),
        .cmp_lvl (cmp_lvl),
        .cnt     (cnt_val),
        .phase   (phase),
        .cmd     (cnt_cmd),
        .cap     (cap_cmd)
    );

    dslope_result u_res (
        .clk  (clk),
        .rst  (rst),
        .cap  (cap_cmd),
        .hold (hold_in),
        .cnt  (cnt_val),
        .rdg  (rdg),
        .ovr  (rdg_ovr),
        .seg  (seg_out)
    );

    assign ph_az    = (phase == PH_AZ);
    assign ph_int   = (phase == PH_INT);
    assign ph_deint = (phase == PH_DEINT);
    assign rdg_bcd  = rdg;
endmodule

// File: rtl/dslope_sequencer_chk.sv
module dslope_sequencer_chk #(
    parameter int unsigned BW            = 16,
    parameter int unsigned DEINT_CLK_MAX = 8000,
    parameter logic [BW-1:0] OVR_READ    = 16'h1999
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          hold_in,
    input logic          ph_az,
    input logic          ph_int,
    input logic          ph_deint,
    input logic [BW-1:0] rdg_bcd,
    input logic          rdg_ovr
);
    function automatic bit digits_ok(input logic [BW-1:0] v);
        for (int i = 0; i < BW / 4; i++) begin
            if (v[4*i +: 4] > 4'd9) return 1'b0;
        end
        return 1'b1;
    endfunction

    int unsigned deint_run;

    always_ff @(posedge clk) begin
        if (rst)           deint_run <= 0;
        else if (ph_deint) deint_run <= deint_run + 1;
        else               deint_run <= 0;
    end

    p_phase_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({ph_az, ph_int, ph_deint}) == 1);

    p_int_to_deint_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ph_int) |-> ph_deint);

    p_deint_to_az_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ph_deint) |-> ph_az);

    p_az_to_int_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ph_az) |-> ph_int);

    p_phase_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable({ph_az, ph_int, ph_deint}));

    p_capture_in_deint_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable({rdg_bcd, rdg_ovr}) |-> $past(ph_deint));

    p_digit_range_r5: assert property (@(posedge clk) disable iff (rst)
        digits_ok(rdg_bcd));

    p_ovr_reading_r6: assert property (@(posedge clk) disable iff (rst)
        rdg_ovr |-> (rdg_bcd == OVR_READ));

    p_deint_window_r6: assert property (@(posedge clk) disable iff (rst)
        deint_run <= DEINT_CLK_MAX);

    p_hold_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        hold_in |=> ($stable(rdg_bcd) && $stable(rdg_ovr)));
endmodule

bind dslope_sequencer dslope_sequencer_chk #(
    .BW            (dslope_pkg::BCD_W),
    .DEINT_CLK_MAX (PRESCALE * DEINT_MAX),
    .OVR_READ      (dslope_pkg::to_bcd(DEINT_MAX - 1))
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (pre_tick),
    .hold_in  (hold_in),
    .ph_az    (ph_az),
    .ph_int   (ph_int),
    .ph_deint (ph_deint),
    .rdg_bcd  (rdg_bcd),
    .rdg_ovr  (rdg_ovr)
);

// File: tb/dslope_sequencer_bench.sv
module dslope_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp = 1'b0;
    logic        hold = 1'b0;
    logic        ph_az, ph_int, ph_deint;
    logic [15:0] rdg_bcd;
    logic        rdg_ovr;
    logic [27:0] seg_out;

    always #2 clk = ~clk;

    dslope_sequencer u_dslope_sequencer (
        .clk      (clk),
        .rst      (rst),
        .cmp_in   (cmp),
        .hold_in  (hold),
        .ph_az    (ph_az),
        .ph_int   (ph_int),
        .ph_deint (ph_deint),
        .rdg_bcd  (rdg_bcd),
        .rdg_ovr  (rdg_ovr),
        .seg_out  (seg_out)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    longint      cyc = 0;
    longint      rel_cyc = 0;
    longint      prev_int = 0;
    bit          have_prev = 1'b0;
    bit          first_int = 1'b1;
    logic [15:0] last_rdg = 16'h0000;
    logic        last_ovr = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] dec2bcd(input int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    function automatic logic [6:0] exp_seg(input logic [3:0] d);
        logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                               7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
        return (d <= 4'd9) ? t[d] : 7'h00;
    endfunction

    task automatic check_seg(input string tag);
        for (int i = 0; i < 4; i++) begin
            check(seg_out[7*i +: 7] == exp_seg(rdg_bcd[4*i +: 4]), "R9", tag,
                  seg_out[7*i +: 7], exp_seg(rdg_bcd[4*i +: 4]));
        end
    endtask

    task automatic check_onehot(input string tag);
        check($countones({ph_az, ph_int, ph_deint}) == 1, "R2", tag,
              {ph_az, ph_int, ph_deint}, 3'b001);
    endtask

    // wait at negedges until the chosen phase is high: 0 az, 1 int, 2 deint
    task automatic wait_phase(input int p);
        bit hit;
        do begin
            @(negedge clk);
            case (p)
                0:       hit = ph_az;
                1:       hit = ph_int;
                default: hit = ph_deint;
            endcase
        end while (!hit);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        check(ph_az && !ph_int && !ph_deint, "R1", "reset phase",
              {ph_az, ph_int, ph_deint}, 3'b100);
        check(rdg_bcd == 16'h0000, "R1", "reset reading", rdg_bcd, 0);
        check(rdg_ovr == 1'b0, "R1", "reset overrange", rdg_ovr, 0);
        check_seg("reset segments");
        rst = 1'b0;
        rel_cyc = cyc;
    endtask

    // one full conversion; crossing after n counts when toggle is set
    task automatic t_convert(input int n, input bit toggle, input bit upd, input string tag);
        longint t0, t1, t2, exp_len;
        logic [15:0] exp_rdg;
        logic        exp_ovr;
        wait_phase(1);
        t0 = cyc;
        if (first_int) begin
            check(t0 - rel_cyc == 12000, "R1", "first auto-zero length", t0 - rel_cyc, 12000);
            first_int = 1'b0;
        end
        if (have_prev)
            check(t0 - prev_int == 16000, "R7", "conversion length", t0 - prev_int, 16000);
        prev_int  = t0;
        have_prev = 1'b1;
        check_onehot({tag, " int"});
        wait_phase(2);
        t1 = cyc;
        check(t1 - t0 == 4000, "R3", "integrate length", t1 - t0, 4000);
        check_onehot({tag, " deint"});
        if (toggle) begin
            repeat (4 * n) @(negedge clk);
            cmp = ~cmp;
        end
        wait_phase(0);
        t2 = cyc;
        exp_len = toggle ? 4 * (n + 1) : 8000;
        check(t2 - t1 == exp_len, toggle ? "R4" : "R6", {tag, " de-integrate length"},
              t2 - t1, exp_len);
        check_onehot({tag, " az"});
        if (!upd) begin
            exp_rdg = last_rdg;
            exp_ovr = last_ovr;
        end else if (toggle) begin
            exp_rdg = dec2bcd(n);
            exp_ovr = 1'b0;
        end else begin
            exp_rdg = dec2bcd(1999);
            exp_ovr = 1'b1;
        end
        check(rdg_bcd == exp_rdg, upd ? (toggle ? "R5" : "R6") : "R8",
              {tag, " reading"}, rdg_bcd, exp_rdg);
        check(rdg_ovr == exp_ovr, upd ? (toggle ? "R5" : "R6") : "R8",
              {tag, " overrange"}, rdg_ovr, exp_ovr);
        check_seg({tag, " segments"});
        last_rdg = rdg_bcd;
        last_ovr = rdg_ovr;
    endtask

    task automatic t_hold();
        hold = 1'b1;
        t_convert(321, 1'b1, 1'b0, "R8 held conversion");
        hold = 1'b0;
        t_convert(1234, 1'b1, 1'b1, "R8 released conversion");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_convert(500, 1'b1, 1'b1, "R5 mid-scale");
        t_convert(0, 1'b1, 1'b1, "R4 zero count");
        t_convert(1999, 1'b1, 1'b1, "R5 last count");
        t_hold();
        t_convert(0, 1'b0, 1'b1, "R6 no crossing");
        t_convert(7, 1'b1, 1'b1, "R6 recovery");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule